// File: doc/BRIEF.md
# Horizontal Sync Presence Monitor with Probation Muting

This block watches an already-separated, active-low horizontal sync stream with a free-running system clock. It measures the number of clock cycles between consecutive falling sync edges and classifies every line as in-window or out-of-window against a frequency band set by parameters. The nominal rate is 15.7 kHz and the tolerance is 4 kHz. Both bounds become cycle counts derived from the clock frequency.

A three-state supervisor uses these classifications to decide whether the gated outputs are enabled. The gated outputs are horizontal sync, composite sync, vertical sync, back porch and field parity. After a bad line, a grace period starts during which the outputs keep passing. If that period runs out, every gated output is forced to logic high. The outputs come back only after a run of consecutive good lines. A status port reports the supervisor state, and a one-cycle strobe marks each classification.

Top module: `sync_presence_mon`

## Requirements
- R1: An interval is good when it is at least MIN and at most MAX clock cycles. MIN is ceil(CLK_HZ/(NOM_HZ+TOL_HZ)) and MAX is floor(CLK_HZ/(NOM_HZ-TOL_HZ)). Each classification raises `line_stb_o` for exactly one cycle, and `line_ok_o` is high in that cycle only for a good interval.
- R2: If no falling edge arrives within MAX cycles of the previous one, exactly one bad classification is made at that point. The edge that finally ends the gap is not classified and only restarts measurement.
- R3: Reset is synchronous and active-low. It leaves the block muted (`state_o` = 2) with the good-line run at zero. The first falling edge after reset only starts measurement.
- R4: In the enabled state (`state_o` = 0), a bad classification moves the block to probation (`state_o` = 1). During probation the outputs stay enabled and sync keeps passing.
- R5: Probation without recovery lasts exactly PROB cycles, where PROB = CLK_HZ*PROB_US/1e6. After that the state becomes muted.
- R6: While muted, `out_en_o` is low and all five gated outputs are 1 whatever their inputs are.
- R7: In probation, LOCK consecutive good lines (default 8) received before expiry return the block to enabled.
- R8: In the muted state, the block becomes enabled only on the LOCK-th consecutive good line. Fewer good lines leave it muted.
- R9: A bad classification clears the consecutive-good count. It does not restart a probation timer that is already running.
- R10: When not muted, `out_en_o` is high and each gated output equals its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_n_i | input | 1 | Separated horizontal sync, active low |
| csync_n_i | input | 1 | Composite sync, active low |
| vsync_n_i | input | 1 | Vertical sync, active low |
| bporch_n_i | input | 1 | Back-porch flag, active low |
| field_i | input | 1 | Odd/even field indicator |
| hsync_n_o | output | 1 | Gated horizontal sync |
| csync_n_o | output | 1 | Gated composite sync |
| vsync_n_o | output | 1 | Gated vertical sync |
| bporch_n_o | output | 1 | Gated back-porch flag |
| field_o | output | 1 | Gated field indicator |
| out_en_o | output | 1 | High while outputs are enabled |
| state_o | output | 2 | 0 enabled, 1 probation, 2 muted |
| line_stb_o | output | 1 | One-cycle pulse per classified line |
| line_ok_o | output | 1 | Classification result, valid with strobe |

## Verification
Several rules are checked by the assertions on every cycle:
- the muted outputs are held high;
- the outputs pass through whenever the block is not muted;
- the strobe never lasts more than one cycle;
- every bad line seen while enabled leads into probation;
- the probation timer advances by one each cycle without restarting;
- the block leaves the muted state only on a good line.

Other properties can only be shown by the bench's scenarios, because they depend on whole line sequences and absolute counts:
- the exact period bounds at MIN-1, MIN, MAX and MAX+1;
- the single classification for an overlong gap;
- the exact probation length;
- the count of eight consecutive lines needed for recovery, both in probation and when muted.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;

  typedef enum logic [1:0] {
    ST_ENABLED   = 2'd0,
    ST_PROBATION = 2'd1,
    ST_MUTED     = 2'd2
  } mon_state_e;

  // Shortest legal line in clock cycles: highest frequency, rounded up.
  function automatic int unsigned min_period_cyc(longint unsigned clk_hz,
                                                 longint unsigned nom_hz,
                                                 longint unsigned tol_hz);
    longint unsigned hi;
    hi = nom_hz + tol_hz;
    return 32'((clk_hz + hi - 1) / hi);
  endfunction

  // Longest legal line in clock cycles: lowest frequency, rounded down.
  function automatic int unsigned max_period_cyc(longint unsigned clk_hz,
                                                 longint unsigned nom_hz,
                                                 longint unsigned tol_hz);
    return 32'(clk_hz / (nom_hz - tol_hz));
  endfunction

  // Grace period length in clock cycles.
  function automatic int unsigned probation_cyc(longint unsigned clk_hz,
                                                longint unsigned dur_us);
    return 32'((clk_hz * dur_us) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/sync_edge_det.sv
module sync_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n_i,
  output logic fall_o
);
  logic cur_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q  <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      cur_q  <= sync_n_i;
      prev_q <= cur_q;
    end
  end

  assign fall_o = prev_q & ~cur_q;
endmodule

// File: rtl/period_meter.sv
module period_meter #(
  parameter int unsigned       CNT_W = 12,
  parameter logic [CNT_W-1:0]  MIN_C = '0,
  parameter logic [CNT_W-1:0]  MAX_C = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_i,
  output logic stb_o,
  output logic ok_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             in_win;
  logic             sat_hit;

  assign in_win  = (cnt_q >= MIN_C) && (cnt_q <= MAX_C);
  assign sat_hit = armed_q && !fall_i && (cnt_q == MAX_C);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      stb_o   <= 1'b0;
      ok_o    <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      ok_o  <= 1'b0;
      if (fall_i) begin
        cnt_q   <= CNT_W'(1);
        armed_q <= 1'b1;
        if (armed_q) begin
          stb_o <= 1'b1;
          ok_o  <= in_win;
        end
      end else if (sat_hit) begin
        stb_o   <= 1'b1;
        armed_q <= 1'b0;
      end else if (armed_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/lock_fsm.sv
module lock_fsm
  import sync_mon_pkg::*;
#(
  parameter int unsigned       RUN_W  = 4,
  parameter logic [RUN_W-1:0]  LOCK_C = RUN_W'(8),
  parameter int unsigned       TMR_W  = 12,
  parameter logic [TMR_W-1:0]  PROB_C = TMR_W'(100)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              good_i,
  input  logic              bad_i,
  output mon_state_e        state_o,
  output logic [TMR_W-1:0]  tmr_o
);
  mon_state_e       st_q;
  logic [RUN_W-1:0] run_q;
  logic [TMR_W-1:0] tmr_q;
  logic             run_done;
  logic             expired;

  assign run_done = good_i && (run_q == LOCK_C - RUN_W'(1));
  assign expired  = (tmr_q == PROB_C - TMR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_MUTED;
      run_q <= '0;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        ST_MUTED: begin
          if (run_done) begin
            st_q  <= ST_ENABLED;
            run_q <= '0;
          end else if (good_i) begin
            run_q <= run_q + RUN_W'(1);
          end else if (bad_i) begin
            run_q <= '0;
          end
        end
        ST_ENABLED: begin
          if (bad_i) begin
            st_q  <= ST_PROBATION;
            tmr_q <= '0;
            run_q <= '0;
          end
        end
        ST_PROBATION: begin
          tmr_q <= tmr_q + TMR_W'(1);
          if (run_done) begin
            st_q  <= ST_ENABLED;
            run_q <= '0;
          end else begin
            if (good_i)     run_q <= run_q + RUN_W'(1);
            else if (bad_i) run_q <= '0;
            if (expired) begin
              st_q  <= ST_MUTED;
              run_q <= '0;
            end
          end
        end
        default: begin
          st_q  <= ST_MUTED;
          run_q <= '0;
        end
      endcase
    end
  end

  assign state_o = st_q;
  assign tmr_o   = tmr_q;
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int unsigned N = 5
) (
  input  logic         en_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign q_o[g] = en_i ? d_i[g] : 1'b1;
  end
endmodule

// File: rtl/sync_presence_mon.sv
module sync_presence_mon
  import sync_mon_pkg::*;
#(
  parameter longint unsigned CLK_HZ     = 27_000_000,
  parameter longint unsigned NOM_HZ     = 15_700,
  parameter longint unsigned TOL_HZ     = 4_000,
  parameter longint unsigned PROB_US    = 2_500,
  parameter int unsigned     LOCK_LINES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hsync_n_i,
  input  logic       csync_n_i,
  input  logic       vsync_n_i,
  input  logic       bporch_n_i,
  input  logic       field_i,
  output logic       hsync_n_o,
  output logic       csync_n_o,
  output logic       vsync_n_o,
  output logic       bporch_n_o,
  output logic       field_o,
  output logic       out_en_o,
  output logic [1:0] state_o,
  output logic       line_stb_o,
  output logic       line_ok_o
);
  localparam int unsigned MIN_P  = min_period_cyc(CLK_HZ, NOM_HZ, TOL_HZ);
  localparam int unsigned MAX_P  = max_period_cyc(CLK_HZ, NOM_HZ, TOL_HZ);
  localparam int unsigned PROB_P = probation_cyc(CLK_HZ, PROB_US);
  localparam int unsigned CNT_W  = $clog2(MAX_P + 2);
  localparam int unsigned TMR_W  = $clog2(PROB_P + 1);
  localparam int unsigned RUN_W  = $clog2(LOCK_LINES + 1);
  localparam int unsigned NSIG   = 5;

  localparam logic [CNT_W-1:0] MIN_C  = CNT_W'(MIN_P);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_P);
  localparam logic [TMR_W-1:0] PROB_C = TMR_W'(PROB_P);
  localparam logic [RUN_W-1:0] LOCK_C = RUN_W'(LOCK_LINES);

  // Named internal events, also watched by the bound checker.
  logic             fall_evt;
  logic             good_evt;
  logic             bad_evt;
  mon_state_e       mon_state;
  logic [TMR_W-1:0] prob_tmr;
  logic [31:0]      prob_tmr_w;
  logic [NSIG-1:0]  in_bus;
  logic [NSIG-1:0]  out_bus;

  sync_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_n_i (hsync_n_i),
    .fall_o   (fall_evt)
  );

  period_meter #(
    .CNT_W (CNT_W),
    .MIN_C (MIN_C),
    .MAX_C (MAX_C)
  ) u_meter (
    .clk    (clk),
    .rst_n  (rst_n),
    .fall_i (fall_evt),
    .stb_o  (line_stb_o),
    .ok_o   (line_ok_o)
  );

  assign good_evt = line_stb_o & line_ok_o;
  assign bad_evt  = line_stb_o & ~line_ok_o;

  lock_fsm #(
    .RUN_W  (RUN_W),
    .LOCK_C (LOCK_C),
    .TMR_W  (TMR_W),
    .PROB_C (PROB_C)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .good_i  (good_evt),
    .bad_i   (bad_evt),
    .state_o (mon_state),
    .tmr_o   (prob_tmr)
  );

  assign prob_tmr_w = 32'(prob_tmr);
  assign out_en_o   = (mon_state != ST_MUTED);
  assign state_o    = mon_state;
  assign in_bus     = {hsync_n_i, csync_n_i, vsync_n_i, bporch_n_i, field_i};

  out_gate #(.N(NSIG)) u_gate (
    .en_i (out_en_o),
    .d_i  (in_bus),
    .q_o  (out_bus)
  );

  assign {hsync_n_o, csync_n_o, vsync_n_o, bporch_n_o, field_o} = out_bus;
endmodule

// File: rtl/sync_presence_chk.sv
module sync_presence_chk
  import sync_mon_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input mon_state_e  state,
  input logic        good,
  input logic        bad,
  input logic        stb,
  input logic        ok,
  input logic [31:0] tmr,
  input logic [4:0]  in_bus,
  input logic [4:0]  out_bus,
  input logic        out_en
);
  AST_MUTE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUTED) |-> (out_bus == 5'h1f && !out_en)); // R6
  AST_PASS_WHEN_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_MUTED) |-> (out_bus == in_bus && out_en)); // R10
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb); // R1
  AST_OK_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> stb); // R1
  AST_BAD_TO_PROB: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENABLED && bad) |=> (state == ST_PROBATION)); // R4
  AST_TMR_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PROBATION && $past(state) == ST_PROBATION)
      |-> (tmr == $past(tmr) + 32'd1)); // R9
  AST_UNMUTE_ON_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ENABLED && $past(state) == ST_MUTED) |-> $past(good)); // R8
  AST_MUTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_MUTED && !good) |=> (state == ST_MUTED)); // R8
endmodule

bind sync_presence_mon sync_presence_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .state   (mon_state),
  .good    (good_evt),
  .bad     (bad_evt),
  .stb     (line_stb_o),
  .ok      (line_ok_o),
  .tmr     (prob_tmr_w),
  .in_bus  (in_bus),
  .out_bus (out_bus),
  .out_en  (out_en_o)
);

// File: tb/tb_sync_presence_mon.sv
`timescale 1ns/1ps
module tb_sync_presence_mon;
  localparam longint unsigned CLK_HZ = 1_000_000;
  localparam longint unsigned NOM    = 15_700;
  localparam longint unsigned TOL    = 4_000;
  localparam longint unsigned PUS    = 2_500;
  localparam int unsigned     LOCK   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b1, cs = 1'b1, vs = 1'b1, bp = 1'b1, fld = 1'b1;
  logic hs_o, cs_o, vs_o, bp_o, fld_o, en_o, stb_o, ok_o;
  logic [1:0] st_o;

  always #5 clk = ~clk;

  sync_presence_mon #(.CLK_HZ(CLK_HZ), .NOM_HZ(NOM), .TOL_HZ(TOL),
                      .PROB_US(PUS), .LOCK_LINES(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .hsync_n_i(hs), .csync_n_i(cs), .vsync_n_i(vs),
    .bporch_n_i(bp), .field_i(fld), .hsync_n_o(hs_o), .csync_n_o(cs_o),
    .vsync_n_o(vs_o), .bporch_n_o(bp_o), .field_o(fld_o), .out_en_o(en_o),
    .state_o(st_o), .line_stb_o(stb_o), .line_ok_o(ok_o));

  // Bounds restated by search rather than division.
  function automatic int lo_bound();
    int n = 1;
    while (longint'(n) * (NOM + TOL) < CLK_HZ) n++;
    return n;
  endfunction
  function automatic int hi_bound();
    int n = 1;
    while (longint'(n + 1) * (NOM - TOL) <= CLK_HZ) n++;
    return n;
  endfunction
  function automatic int grace_len();
    return int'(CLK_HZ / 1000) * int'(PUS) / 1000;
  endfunction
  function automatic bit is_good(int p);
    return (p >= lo_bound()) && (p <= hi_bound());
  endfunction

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, good_n = 0, bad_n = 0, prob_start = 0, prob_len = -1;
  logic [1:0] prev_st = 2'd2;
  bit done = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (stb_o) begin
        if (ok_o) good_n++; else bad_n++;
      end
      if (st_o == 2'd1 && prev_st != 2'd1) prob_start = cyc;
      if (st_o == 2'd2 && prev_st == 2'd1) prob_len = cyc - prob_start;
    end
    prev_st = st_o;
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic line(int p);
    @(negedge clk) hs = 1'b0;
    repeat (3) @(negedge clk);
    hs = 1'b1;
    repeat (p - 4) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic lines(int p, int n);
    for (int i = 0; i < n; i++) line(p);
  endtask

  // One isolated interval of length p: returns strobe deltas.
  task automatic single(int p, output int dg, output int db);
    int g0, b0;
    idle(hi_bound() + 20);
    g0 = good_n; b0 = bad_n;
    line(p);
    @(negedge clk) hs = 1'b0;
    idle(3); hs = 1'b1; idle(6);
    dg = good_n - g0; db = bad_n - b0;
  endtask

  initial begin
    int dg, db, g0, b0, eg, eb, p;
    int mn, mx;
    void'($urandom(32'h5EED_0042));
    mn = lo_bound(); mx = hi_bound();
    // Reset state
    cs = 1'b0; vs = 1'b0; bp = 1'b0; fld = 1'b0;
    idle(5);
    chk("R3 state after reset", st_o, 2);
    chk("R6 muted outputs high", {hs_o, cs_o, vs_o, bp_o, fld_o}, 5'h1f);
    chk("R6 out_en low", en_o, 0);
    @(negedge clk) rst_n = 1'b1;
    cs = 1'b1; vs = 1'b1; bp = 1'b1; fld = 1'b1;
    idle(10);
    // Lock from muted: first edge only arms
    lines(64, 8);
    chk("R8 seven good lines stay muted", st_o, 2);
    chk("R3 first edge not classified", good_n, 7);
    line(64);
    chk("R8 eighth good line enables", st_o, 0);
    vs = 1'b0; fld = 1'b0; cs = 1'b0;
    idle(1);
    chk("R10 pass-through", {cs_o, vs_o, bp_o, fld_o}, 4'b0010);
    chk("R10 out_en high", en_o, 1);
    vs = 1'b1; fld = 1'b1; cs = 1'b1;
    // Random in-window lines
    b0 = bad_n;
    for (int i = 0; i < 30; i++) line($urandom_range(mx, mn));
    chk("R1 random in-window no bad", bad_n - b0, 0);
    chk("R1 random in-window stays enabled", st_o, 0);
    // Probation without restart
    line(30); line(64);
    chk("R4 bad line enters probation", st_o, 1);
    cs = 1'b0; idle(1);
    chk("R4 probation keeps passing", cs_o, 0);
    cs = 1'b1;
    lines(64, 5); line(30); lines(64, 7);
    chk("R9 broken run stays probation", st_o, 1);
    idle(grace_len());
    chk("R5 muted after expiry", st_o, 2);
    chk("R9 timer not restarted", prob_len, grace_len());
    cs = 1'b0; idle(1);
    chk("R6 muted composite high", cs_o, 1);
    cs = 1'b1;
    // Muted: run broken then completed
    lines(64, 5); line(30); lines(64, 8);
    chk("R9 run cleared while muted", st_o, 2);
    line(64);
    chk("R8 relock after full run", st_o, 0);
    // Probation recovery
    line(30); lines(64, 8);
    chk("R7 seven good keep probation", st_o, 1);
    line(64);
    chk("R7 eighth good restores", st_o, 0);
    // Signal loss from enabled
    lines(64, 2);
    @(negedge clk) hs = 1'b0; idle(3); hs = 1'b1;
    idle(mx - 10);
    chk("R2 within max still enabled", st_o, 0);
    idle(20);
    chk("R2 loss enters probation", st_o, 1);
    // Boundary intervals
    single(mn - 1, dg, db); chk("R1 MIN-1 bad", db, 1); chk("R1 MIN-1 no good", dg, 0);
    single(mn, dg, db);     chk("R1 MIN good", dg, 1);  chk("R1 MIN no bad", db, 0);
    single(mx, dg, db);     chk("R1 MAX good", dg, 1);  chk("R1 MAX no bad", db, 0);
    single(mx + 1, dg, db); chk("R2 MAX+1 one bad", db, 1); chk("R2 MAX+1 no good", dg, 0);
    // Random mixed group
    idle(mx + 20);
    g0 = good_n; b0 = bad_n; eg = 0; eb = 0;
    for (int i = 0; i < 25; i++) begin
      p = $urandom_range(100, 30);
      if (is_good(p)) eg++; else eb++;
      line(p);
    end
    @(negedge clk) hs = 1'b0; idle(3); hs = 1'b1; idle(6);
    chk("R1 random mix good count", good_n - g0, eg);
    chk("R2 random mix bad count", bad_n - b0, eb);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule